// File: doc/BRIEF.md
# SDRAM Command Bank-State Tracker

This block watches the command bus of a four-bank double-data-rate SDRAM and keeps its own copy of what the memory is doing. On every rising clock edge it decodes chip select, row strobe, column strobe and write enable, together with the bank and address inputs. For each bank it records whether a row is open and which row that is. It counts the length of any read or write burst. When a burst was issued with auto-precharge, it closes the bank by itself when the burst finishes. It also keeps a copy of the mode register.

The tracker is passive and never drives the bus. It turns command-ordering mistakes into a three-bit violation code. A command that breaks a rule is ignored by the tracker's state, so the copy stays consistent with a memory that would refuse the command. Command encodings (chip select low, then RAS#/CAS#/WE#): 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 000 MODE REGISTER SET, 001 REFRESH, 110 BURST TERMINATE, 111 NOP. REFRESH and BURST TERMINATE leave the tracked state unchanged.

Top module: `sdram_bank_tracker`

## Requirements
- R1: A cycle with cs_n high, or with RAS#/CAS#/WE# = 111, changes no output except that it clears viol_code and lets the A8 self-clear and the wait countdown proceed. REFRESH (001) and BURST TERMINATE (110) behave the same way, apart from being flagged during the mode-load wait (R11).
- R2: ACTIVE to an idle bank sets bank_active[ba] and stores addr in that bank's slice open_rows[ba*13 +: 13]. Both are visible after the edge that samples the command.
- R3: ACTIVE to a bank that is already active gives viol_code 2. That bank's stored row is left unchanged.
- R4: READ or WRITE to an idle bank gives viol_code 1 and starts no burst.
- R5: A legal READ or WRITE raises burst_busy for BL/2 cycles after its edge. BL comes from mode_reg[2:0]: code 1 gives 2, code 2 gives 4, code 3 gives 8, and any other code gives 2.
- R6: A legal READ or WRITE with addr[10] = 1 closes its bank at the edge where burst_busy falls.
- R7: PRECHARGE with addr[10] = 1 closes all banks. With addr[10] = 0 it closes bank ba. Precharging an idle bank is not a violation. A precharge that covers a bank with a pending auto-precharge cancels that pending close.
- R8: MODE REGISTER SET with ba = 0, all banks idle and no burst running loads addr into mode_reg. MODE REGISTER SET with ba not 0 is ignored.
- R9: MODE REGISTER SET with ba = 0 while any bank is active or a burst is running gives viol_code 3, and mode_reg stays unchanged.
- R10: mode_reg[8] reads back as loaded for one cycle and then returns to 0. All other bits are kept until the next load.
- R11: For the two command edges after an accepted mode load, any command other than NOP or deselect gives viol_code 4 and is ignored.
- R12: viol_code is nonzero only during the single cycle after an offending command.
- R13: A legal READ/WRITE issued while a burst is running restarts the burst count. If the running burst had auto-precharge on another bank, that bank closes at this edge. If it was on the same bank, the new command's addr[10] decides.
- R14: After reset, all banks are idle, mode_reg is 0, burst_busy is 0 and viol_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column or mode value; bit 10 selects auto-precharge or all-bank precharge |
| bank_active | output | 4 | One bit per bank, 1 while a row is open |
| open_rows | output | 52 | Stored row of each bank, bank n at bits n*13 +: 13 |
| burst_busy | output | 1 | High while a burst is counting down |
| mode_reg | output | 13 | Tracked mode register |
| viol_code | output | 3 | 0 none, 1 access to idle bank, 2 ACTIVE to active bank, 3 mode load while busy, 4 command during mode wait |

## Verification
The hardest case to reach is a burst cut short while an auto-precharge is pending on a different bank. That takes two open banks, a mode register holding a burst longer than two, an auto-precharge access, and a second access landing on exactly the next edge. The directed phase builds this sequence step by step. A sweep then cycles through every control combination against every bank and both values of address bit 10, with varying rows. A reference model in the bench follows the command rules, so overlapping bursts, precharges racing auto-precharge ends and mode loads against busy states are all compared every cycle.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;

  typedef enum logic [2:0] {
    V_NONE        = 3'd0,
    V_IDLE_ACCESS = 3'd1,
    V_DOUBLE_ACT  = 3'd2,
    V_MRS_BUSY    = 3'd3,
    V_MRS_WAIT    = 3'd4
  } viol_e;

  localparam int AP_BIT   = 10;
  localparam int SELF_BIT = 8;
  localparam int CNT_W    = 3;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) c = CMD_NOP;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        3'b110:  c = CMD_BST;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  // clock cycles taken by a burst: half the burst length
  function automatic logic [CNT_W-1:0] burst_cycles(input logic [2:0] code);
    logic [CNT_W-1:0] n;
    unique case (code)
      3'd2:    n = CNT_W'(2);
      3'd3:    n = CNT_W'(4);
      default: n = CNT_W'(1);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd,
  output logic cmd_present
);
  assign cmd         = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign cmd_present = (cmd != CMD_NOP);
endmodule

// File: rtl/sbt_bank.sv
module sbt_bank #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      row    <= '0;
    end else if (open_en) begin
      active <= 1'b1;
      row    <= row_in;
    end else if (close_en) begin
      active <= 1'b0;
    end
  end

  p_open_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    open_en |-> !active);
  p_close_goes_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (close_en && !open_en) |=> !active);
endmodule

// File: rtl/sbt_burst.sv
module sbt_burst
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BA_W-1:0]      start_bank,
  input  logic                 start_ap,
  input  logic [2:0]           bl_code,
  input  logic [NUM_BANKS-1:0] pre_mask,
  output logic                 busy,
  output logic                 burst_end,
  output logic [NUM_BANKS-1:0] ap_close_mask
);
  localparam logic [NUM_BANKS-1:0] ONE = {{(NUM_BANKS-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             ap_pend_q;
  logic [BA_W-1:0]  ap_bank_q;
  logic             cut_other;
  logic             ap_fire;

  assign busy      = (cnt_q != '0);
  assign burst_end = (cnt_q == CNT_W'(1)) && !start;
  assign cut_other = start && busy && ap_pend_q && (ap_bank_q != start_bank);
  assign ap_fire   = ap_pend_q && (burst_end || cut_other);
  assign ap_close_mask = ap_fire ? (ONE << ap_bank_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ap_pend_q <= 1'b0;
      ap_bank_q <= '0;
    end else if (start) begin
      cnt_q     <= burst_cycles(bl_code);
      ap_pend_q <= start_ap;
      ap_bank_q <= start_bank;
    end else begin
      if (busy) cnt_q <= cnt_q - CNT_W'(1);
      if (burst_end || pre_mask[ap_bank_q]) ap_pend_q <= 1'b0;
    end
  end

  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !busy);
  p_ap_within_burst_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ap_pend_q |-> busy);
endmodule

// File: rtl/sbt_mode.sv
module sbt_mode
  import sbt_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int MRS_WAIT = 2,
  localparam int WW = $clog2(MRS_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] din,
  output logic [ROW_W-1:0] mode_q,
  output logic             in_wait
);
  logic [WW-1:0] wcnt_q;

  assign in_wait = (wcnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      wcnt_q <= '0;
    end else if (load) begin
      mode_q <= din;
      wcnt_q <= WW'(MRS_WAIT);
    end else begin
      mode_q[SELF_BIT] <= 1'b0;
      if (in_wait) wcnt_q <= wcnt_q - WW'(1);
    end
  end

  p_a8_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ##1 !mode_q[SELF_BIT]);
  p_wait_no_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !load);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int NUM_BANKS = 4,
  parameter int MRS_WAIT  = 2,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bank_active,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       burst_busy,
  output logic [ROW_W-1:0]           mode_reg,
  output logic [2:0]                 viol_code
);
  localparam logic [NUM_BANKS-1:0] ONE = {{(NUM_BANKS-1){1'b0}}, 1'b1};

  cmd_e cmd;
  logic cmd_present;
  logic in_wait;
  logic blocked, sel_active, any_busy;
  logic act_ok, rw_ok, mrs_hit, mrs_ok, pre_hit;
  logic burst_end;
  logic [NUM_BANKS-1:0] sel_mask, pre_mask, open_mask, ap_close_mask, close_mask;
  viol_e viol_next, viol_q;

  sbt_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cmd(cmd), .cmd_present(cmd_present)
  );

  assign sel_mask   = ONE << ba;
  assign sel_active = bank_active[ba];
  assign any_busy   = (|bank_active) || burst_busy;
  assign blocked    = cmd_present && in_wait;

  assign act_ok  = !blocked && (cmd == CMD_ACT) && !sel_active;
  assign rw_ok   = !blocked && ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel_active;
  assign mrs_hit = !blocked && (cmd == CMD_MRS) && (ba == '0);
  assign mrs_ok  = mrs_hit && !any_busy;
  assign pre_hit = !blocked && (cmd == CMD_PRE);

  assign pre_mask   = pre_hit ? (addr[AP_BIT] ? '1 : sel_mask) : '0;
  assign open_mask  = act_ok ? sel_mask : '0;
  assign close_mask = pre_mask | ap_close_mask;

  always_comb begin
    viol_next = V_NONE;
    if (blocked) viol_next = V_MRS_WAIT;
    else begin
      unique case (cmd)
        CMD_ACT:        if (sel_active) viol_next = V_DOUBLE_ACT;
        CMD_RD, CMD_WR: if (!sel_active) viol_next = V_IDLE_ACCESS;
        CMD_MRS:        if ((ba == '0) && any_busy) viol_next = V_MRS_BUSY;
        default:        viol_next = V_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) viol_q <= V_NONE;
    else        viol_q <= viol_next;
  end
  assign viol_code = viol_q;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    sbt_bank #(.ROW_W(ROW_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .open_en(open_mask[i]), .close_en(close_mask[i]),
      .row_in(addr),
      .active(bank_active[i]),
      .row(open_rows[i*ROW_W +: ROW_W])
    );
  end

  sbt_burst #(.NUM_BANKS(NUM_BANKS)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .start(rw_ok), .start_bank(ba), .start_ap(addr[AP_BIT]),
    .bl_code(mode_reg[2:0]), .pre_mask(pre_mask),
    .busy(burst_busy), .burst_end(burst_end), .ap_close_mask(ap_close_mask)
  );

  sbt_mode #(.ROW_W(ROW_W), .MRS_WAIT(MRS_WAIT)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .load(mrs_ok), .din(addr),
    .mode_q(mode_reg), .in_wait(in_wait)
  );

  p_rw_needs_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rw_ok |-> bank_active[ba]);
  p_mrs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_ok |-> (bank_active == '0 && !burst_busy));
  p_open_close_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (open_mask & close_mask) == '0);
  p_ap_end_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && (ap_close_mask != '0)) |=> !burst_busy);
  p_wait_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> (viol_code == 3'd4));
endmodule

// File: tb/sim_sdram_bank_tracker.sv
`timescale 1ns/1ps
module sim_sdram_bank_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic [3:0] bank_active;
  logic [51:0] open_rows;
  logic burst_busy;
  logic [12:0] mode_reg;
  logic [2:0] viol_code;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  bit [3:0]  m_act;
  bit [12:0] m_row [4];
  int        m_cnt;
  bit        m_ap;
  bit [1:0]  m_apb;
  bit [12:0] m_mode;
  int        m_wt;
  int        m_code;
  bit [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  sdram_bank_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .bank_active(bank_active),
    .open_rows(open_rows), .burst_busy(burst_busy), .mode_reg(mode_reg),
    .viol_code(viol_code)
  );

  function automatic int cycles_for(bit [2:0] code);
    int bl;
    bl = (code >= 3'd1 && code <= 3'd3) ? (1 << code) : 2;
    return bl / 2;
  endfunction

  task automatic model_reset();
    m_act = '0; m_cnt = 0; m_ap = 0; m_apb = '0; m_mode = '0; m_wt = 0; m_code = 0;
    for (int k = 0; k < 4; k++) m_row[k] = '0;
  endtask

  task automatic model_step(bit c, bit r, bit s, bit w, bit [1:0] b, bit [12:0] a);
    bit nop;
    int code;
    bit [3:0] opn, cls;
    bit rw, ld;
    nop = c || (r && s && w);
    code = 0; opn = '0; cls = '0; rw = 0; ld = 0;
    if (!nop && m_wt != 0) code = 4;
    else if (!c) begin
      case ({r, s, w})
        3'b011: if (m_act[b]) code = 2; else opn[b] = 1'b1;
        3'b101, 3'b100: if (!m_act[b]) code = 1; else rw = 1;
        3'b010: cls = a[10] ? 4'hF : (4'b0001 << b);
        3'b000: if (b == 2'd0) begin
                  if (m_act != 0 || m_cnt != 0) code = 3; else ld = 1;
                end
        default: ;
      endcase
    end
    if (rw) begin
      if (m_ap && m_cnt != 0 && m_apb != b) cls[m_apb] = 1'b1;
      m_cnt = cycles_for(m_mode[2:0]);
      m_ap = a[10];
      m_apb = b;
    end else begin
      if (m_cnt == 1 && m_ap) begin cls[m_apb] = 1'b1; m_ap = 0; end
      if (m_cnt != 0) m_cnt--;
      if (cls[m_apb]) m_ap = 0;
    end
    if (ld) begin m_mode = a; m_wt = 2; end
    else begin m_mode[8] = 1'b0; if (m_wt != 0) m_wt--; end
    for (int k = 0; k < 4; k++) begin
      if (opn[k]) begin m_act[k] = 1'b1; m_row[k] = a; end
      else if (cls[k]) m_act[k] = 1'b0;
    end
    m_code = code;
  endtask

  task automatic compare(string tag);
    bit [51:0] er;
    er = {m_row[3], m_row[2], m_row[1], m_row[0]};
    vectors++;
    if (bank_active !== m_act || open_rows !== er || burst_busy !== (m_cnt != 0) ||
        mode_reg !== m_mode || viol_code !== 3'(m_code)) begin
      fails++;
      $display("FAIL %s: act=%h rows=%h busy=%b mode=%h code=%0d exp act=%h rows=%h busy=%b mode=%h code=%0d",
               tag, bank_active, open_rows, burst_busy, mode_reg, viol_code,
               m_act, er, (m_cnt != 0), m_mode, m_code);
    end
  endtask

  // drive at negedge, model the rising edge, compare at the next negedge
  task automatic apply(bit c, bit r, bit s, bit w, bit [1:0] b, bit [12:0] a, string tag);
    cs_n = c; ras_n = r; cas_n = s; we_n = w; ba = b; addr = a;
    model_step(c, r, s, w, b, a);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic nop(string tag);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 13'h0, tag);
  endtask
  task automatic act(bit [1:0] b, bit [12:0] row, string tag);
    apply(1'b0, 1'b0, 1'b1, 1'b1, b, row, tag);
  endtask
  task automatic rd(bit [1:0] b, bit ap, string tag);
    apply(1'b0, 1'b1, 1'b0, 1'b1, b, {2'b00, ap, 10'h010}, tag);
  endtask
  task automatic wr(bit [1:0] b, bit ap, string tag);
    apply(1'b0, 1'b1, 1'b0, 1'b0, b, {2'b00, ap, 10'h020}, tag);
  endtask
  task automatic pre(bit [1:0] b, bit all, string tag);
    apply(1'b0, 1'b0, 1'b1, 1'b0, b, {2'b00, all, 10'h0}, tag);
  endtask
  task automatic mrs(bit [1:0] b, bit [12:0] v, string tag);
    apply(1'b0, 1'b0, 1'b0, 1'b0, b, v, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R14 reset");

    apply(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 13'h1FFF, "R1 deselect");
    nop("R1 nop");
    apply(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 13'h0, "R1 refresh");
    mrs(2'd0, 13'h0102, "R8 load");
    nop("R10 a8 clear");
    act(2'd0, 13'h0AAA, "R11 wait flag");
    nop("R12 code pulse");
    act(2'd1, 13'h1ABC, "R2 open");
    act(2'd1, 13'h0123, "R3 double act");
    rd(2'd2, 1'b0, "R4 idle read");
    nop("R12 clear");
    rd(2'd1, 1'b0, "R5 read bl4");
    nop("R5 busy");
    nop("R5 end");
    wr(2'd1, 1'b1, "R6 write ap");
    nop("R6 counting");
    nop("R6 closed");
    act(2'd0, 13'h0001, "R2 open b0");
    act(2'd2, 13'h0002, "R2 open b2");
    act(2'd3, 13'h0003, "R2 open b3");
    pre(2'd2, 1'b0, "R7 single");
    pre(2'd2, 1'b0, "R7 idle pre");
    rd(2'd0, 1'b0, "R5 read");
    mrs(2'd0, 13'h0003, "R9 busy mrs");
    mrs(2'd1, 13'h0003, "R8 ba ignored");
    pre(2'd0, 1'b1, "R7 all");
    mrs(2'd0, 13'h0003, "R8 bl8");
    nop("R11 wait");
    nop("R11 wait");
    act(2'd0, 13'h0111, "R2 after wait");
    act(2'd1, 13'h0222, "R2 open b1");
    rd(2'd0, 1'b1, "R13 ap read");
    rd(2'd1, 1'b0, "R13 cut other");
    nop("R13 run");
    wr(2'd1, 1'b1, "R13 same bank");
    rd(2'd1, 1'b0, "R13 same bank drop");
    for (int k = 0; k < 5; k++) nop("R5 bl8 drain");
    act(2'd2, 13'h0333, "R2 open b2");
    rd(2'd2, 1'b1, "R7 ap pending");
    pre(2'd2, 1'b1, "R7 cancels ap");
    act(2'd2, 13'h0444, "R7 reopen");
    for (int k = 0; k < 4; k++) nop("R7 stays open");

    for (int i = 0; i < 4096; i++) begin
      bit [3:0] ctl;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ctl = 4'(i);
      if (i[7]) ctl[3] = 1'b0;
      apply(ctl[3], ctl[2], ctl[1], ctl[0], 2'(i >> 4), {lfsr[12:11], i[6], lfsr[9:0]},
            "R1 R12 sweep");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule